// File: doc/BRIEF.md
# Raster Operation Read-Modify-Write Unit

This unit sits between a processor's write path and a word-wide memory, and turns every processor write into a raster update of one destination word. The processor hands over a source word, a target address and a two-bit combine code. The unit aligns the source with a barrel shifter and reads the old destination word. It merges the two with the chosen Boolean function, then writes the result back. Only the bit positions enabled by a mask register are changed.

The barrel shifter works on the pair made of the previously accepted source word and the current one. Bits pushed out of one source word therefore reach the next destination word, so a software loop that walks a row of words sees one continuous bit stream. Shift amount and mask live in configuration registers that are loaded through a plain load strobe between operations. Rectangle walking and address generation are left to the processor.

The write port is valid/ready. A word is taken on a clock edge where both `wr_valid` and `wr_ready` are high. While an update is in flight `wr_ready` is low, and the processor must hold its word, address and code stable until it is taken. The memory port is plain: a read enable returns data on the next cycle, and a write enable stores on its own edge.

Top module: `rop_rmw_unit`

## Requirements
- R1: After reset, `busy`, `mem_re` and `mem_we` are low and `wr_ready` is high.
- R2: Combine code 2'b00 (replace) writes the aligned source s' into the enabled bits.
- R3: Combine code 2'b01 (paint) writes d OR s' into the enabled bits, where d is the word read from memory.
- R4: Combine code 2'b10 (invert) writes d XOR s' into the enabled bits.
- R5: Combine code 2'b11 (erase) writes d AND NOT s' into the enabled bits.
- R6: After a word is accepted, the next cycle drives `mem_re` with the address. The cycle after that drives neither enable. The third cycle drives `mem_we` with the same address, and the fourth cycle is idle again.
- R7: `busy` is high and `wr_ready` low from the cycle after acceptance through the write cycle. A word held valid during that time is not taken and triggers no memory access until `wr_ready` returns.
- R8: The stored word is (F(d,s') AND mask) OR (d AND NOT mask): destination bits whose mask bit is 0 keep their old value.
- R9: The aligned source s' is the low DW bits of {prev, src} shifted right by the shift amount. Here prev is the source word of the previously accepted write, and it is zero after reset.
- R10: `cfg_we` loads the shift and mask registers while idle. It has no effect while `busy` is high, and the earlier values stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Processor write word valid |
| wr_ready | output | 1 | Unit can take a write word |
| wr_addr | input | AW | Destination word address |
| wr_src | input | DW | Source word |
| wr_func | input | 2 | Combine code |
| cfg_we | input | 1 | Load shift and mask registers |
| cfg_shift | input | $clog2(DW) | New shift amount |
| cfg_mask | input | DW | New write mask |
| busy | output | 1 | Update in progress |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after `mem_re` |

## Verification
On every cycle the assertions check the ordering of the read, the idle merge cycle and the write. They also check that the write hits the address that was read, that read and write enables never overlap, and that masked-off bits of the written word match the word just read. They also check that a load strobe during an update leaves the mask untouched. The bench scenarios cover what an assertion cannot see alone: the arithmetic result of each of the four combine codes, the carry of source bits across the word boundary through the shifter, and that a word held against back-pressure is later taken exactly once.

// File: rtl/rop_pkg.sv
package rop_pkg;
  typedef enum logic [1:0] {
    FN_REPLACE = 2'b00,
    FN_PAINT   = 2'b01,
    FN_INVERT  = 2'b10,
    FN_ERASE   = 2'b11
  } rop_fn_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_READ   = 2'b01,
    PH_MERGE  = 2'b10,
    PH_WRITE  = 2'b11
  } rop_phase_e;
endpackage

// File: rtl/rop_align.sv
module rop_align #(
  parameter int DW = 16,
  localparam int SW = $clog2(DW)
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] prev,
  input  logic [SW-1:0] amount,
  output logic [DW-1:0] aligned
);
  logic [2*DW-1:0] pair;
  logic [2*DW-1:0] moved;

  always_comb begin
    pair    = {prev, cur};
    moved   = pair >> amount;
    aligned = moved[DW-1:0];
  end
endmodule

// File: rtl/rop_combine.sv
module rop_combine
  import rop_pkg::*;
#(
  parameter int DW = 16
) (
  input  rop_fn_e       fn,
  input  logic [DW-1:0] dst,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] result
);
  logic [DW-1:0] merged;

  always_comb begin
    unique case (fn)
      FN_REPLACE: merged = src;
      FN_PAINT:   merged = dst | src;
      FN_INVERT:  merged = dst ^ src;
      default:    merged = dst & ~src;
    endcase
    result = (merged & mask) | (dst & ~mask);
  end
endmodule

// File: rtl/rop_seq.sv
module rop_seq
  import rop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready,
  output logic busy,
  output logic rd_en,
  output logic merge_en,
  output logic wr_en
);
  rop_phase_e phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:  if (start) phase <= PH_READ;
        PH_READ:  phase <= PH_MERGE;
        PH_MERGE: phase <= PH_WRITE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ready    = (phase == PH_IDLE);
    busy     = (phase != PH_IDLE);
    rd_en    = (phase == PH_READ);
    merge_en = (phase == PH_MERGE);
    wr_en    = (phase == PH_WRITE);
  end

  assert_read_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> rd_en);
  assert_merge_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> merge_en && !wr_en);
  assert_write_after_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    merge_en |=> wr_en);
  assert_idle_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ready && !busy);
endmodule

// File: rtl/rop_rmw_unit.sv
module rop_rmw_unit
  import rop_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8,
  localparam int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_src,
  input  logic [1:0]    wr_func,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_shift,
  input  logic [DW-1:0] cfg_mask,
  output logic          busy,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic          take;
  logic          merge_en;
  logic [SW-1:0] shift_q;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] prev_q;
  logic [DW-1:0] src_q;
  logic [AW-1:0] addr_q;
  rop_fn_e       fn_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] aligned;
  logic [DW-1:0] result;

  assign take = wr_valid && wr_ready;

  rop_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (take),
    .ready    (wr_ready),
    .busy     (busy),
    .rd_en    (mem_re),
    .merge_en (merge_en),
    .wr_en    (mem_we)
  );

  rop_align #(.DW(DW)) u_align (
    .cur     (wr_src),
    .prev    (prev_q),
    .amount  (shift_q),
    .aligned (aligned)
  );

  rop_combine #(.DW(DW)) u_comb (
    .fn     (fn_q),
    .dst    (mem_rdata),
    .src    (src_q),
    .mask   (mask_q),
    .result (result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      mask_q  <= '1;
    end else if (cfg_we && !busy) begin
      shift_q <= cfg_shift;
      mask_q  <= cfg_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      src_q   <= '0;
      addr_q  <= '0;
      fn_q    <= FN_REPLACE;
      wdata_q <= '0;
    end else begin
      if (take) begin
        prev_q <= wr_src;
        src_q  <= aligned;
        addr_q <= wr_addr;
        fn_q   <= rop_fn_e'(wr_func);
      end
      if (merge_en) wdata_q <= result;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  assert_no_rw_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  assert_same_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == $past(mem_addr, 2)) && $past(mem_re, 2));
  assert_mask_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_wdata ^ $past(mem_rdata)) & ~mask_q) == '0);
  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we) |=> $stable(mask_q) && $stable(shift_q));
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !mem_re || $past(mem_we) == 1'b0);
endmodule

// File: tb/sim_rop_rmw_unit.sv
module sim_rop_rmw_unit;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int SW = $clog2(DW);

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_valid = 0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_src = '0;
  logic [1:0]    wr_func = '0;
  logic          cfg_we = 0;
  logic [SW-1:0] cfg_shift = '0;
  logic [DW-1:0] cfg_mask = '0;
  logic          busy;
  logic          mem_re;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int reads = 0;

  logic [DW-1:0] mem    [0:(1<<AW)-1];
  logic [DW-1:0] shadow [0:(1<<AW)-1];
  logic [DW-1:0] prev_m = '0;
  logic [DW-1:0] mask_m = '1;
  logic [SW-1:0] shift_m = '0;

  always #10 clk = ~clk;

  rop_rmw_unit #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_src(wr_src), .wr_func(wr_func),
    .cfg_we(cfg_we), .cfg_shift(cfg_shift), .cfg_mask(cfg_mask),
    .busy(busy), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] seed(int i);
    return DW'(i * 16'h1357) ^ 16'hA5C3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) mem[i] <= seed(i);
      mem_rdata <= '0;
    end else begin
      if (mem_re) begin
        mem_rdata <= mem[mem_addr];
        reads <= reads + 1;
      end
      if (mem_we) mem[mem_addr] <= mem_wdata;
    end
  end

  function automatic logic [DW-1:0] expect_word(logic [DW-1:0] d, logic [DW-1:0] src,
                                                logic [1:0] fn);
    logic [2*DW-1:0] pr;
    logic [DW-1:0] s, f;
    pr = {prev_m, src} >> shift_m;
    s = pr[DW-1:0];
    case (fn)
      2'b00: f = s;
      2'b01: f = d | s;
      2'b10: f = d ^ s;
      default: f = d & ~s;
    endcase
    return (f & mask_m) | (d & ~mask_m);
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(logic [SW-1:0] sh, logic [DW-1:0] m);
    @(negedge clk);
    cfg_we = 1; cfg_shift = sh; cfg_mask = m;
    @(negedge clk);
    cfg_we = 0;
    shift_m = sh; mask_m = m;
  endtask

  task automatic run_op(string tag, logic [AW-1:0] a, logic [DW-1:0] src, logic [1:0] fn);
    logic [DW-1:0] e;
    e = expect_word(shadow[a], src, fn);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_src = src; wr_func = fn;
    @(negedge clk);
    wr_valid = 0;
    while (!wr_ready) @(negedge clk);
    shadow[a] = e; prev_m = src;
    check(tag, mem[a], e);
  endtask

  task automatic t_reset();
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 ready", {15'd0, wr_ready}, 16'd1);
    check("R1 enables", {14'd0, mem_re, mem_we}, 16'd0);
  endtask

  task automatic t_functions();
    run_op("R2 replace", 8'd3, 16'h0FF0, 2'b00);
    run_op("R3 paint", 8'd4, 16'h00F1, 2'b01);
    run_op("R4 invert", 8'd5, 16'hFFFF, 2'b10);
    run_op("R5 erase", 8'd6, 16'h3C3C, 2'b11);
  endtask

  task automatic t_sequence();
    logic [DW-1:0] e;
    e = expect_word(shadow[8'd9], 16'h1234, 2'b10);
    @(negedge clk);
    wr_valid = 1; wr_addr = 8'd9; wr_src = 16'h1234; wr_func = 2'b10;
    @(negedge clk);
    wr_valid = 0;
    check("R6 read cycle", {7'd0, mem_re, mem_addr}, {7'd0, 1'b1, 8'd9});
    check("R7 busy read", {14'd0, busy, wr_ready}, 16'd2);
    @(negedge clk);
    check("R6 merge cycle", {14'd0, mem_re, mem_we}, 16'd0);
    @(negedge clk);
    check("R6 write cycle", {7'd0, mem_we, mem_addr}, {7'd0, 1'b1, 8'd9});
    check("R7 busy write", {14'd0, busy, wr_ready}, 16'd2);
    @(negedge clk);
    check("R6 idle again", {14'd0, busy, wr_ready}, 16'd1);
    shadow[8'd9] = e; prev_m = 16'h1234;
    check("R4 seq result", mem[8'd9], e);
  endtask

  task automatic t_mask();
    set_cfg('0, 16'hF00F);
    run_op("R8 mask replace", 8'd12, 16'h5A5A, 2'b00);
    run_op("R8 mask invert", 8'd13, 16'hFFFF, 2'b10);
  endtask

  task automatic t_shift();
    set_cfg(4'd4, 16'hFFFF);
    run_op("R9 shift first", 8'd20, 16'hABCD, 2'b00);
    run_op("R9 shift carry", 8'd21, 16'h1234, 2'b00);
    set_cfg(4'd15, 16'hFFFF);
    run_op("R9 shift max", 8'd22, 16'h8001, 2'b01);
    set_cfg('0, 16'hFFFF);
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] ea, eb;
    int r0;
    r0 = reads;
    ea = expect_word(shadow[8'd30], 16'h0F0F, 2'b00);
    @(negedge clk);
    wr_valid = 1; wr_addr = 8'd30; wr_src = 16'h0F0F; wr_func = 2'b00;
    @(negedge clk);
    shadow[8'd30] = ea; prev_m = 16'h0F0F;
    wr_addr = 8'd31; wr_src = 16'hF0F0; wr_func = 2'b01;
    eb = expect_word(shadow[8'd31], 16'hF0F0, 2'b01);
    check("R7 held not ready", {15'd0, wr_ready}, 16'd0);
    while (!wr_ready) @(negedge clk);
    check("R7 one read while held", 16'(reads - r0), 16'd1);
    @(negedge clk);
    wr_valid = 0;
    while (!wr_ready) @(negedge clk);
    shadow[8'd31] = eb; prev_m = 16'hF0F0;
    check("R7 first word", mem[8'd30], ea);
    check("R7 held word", mem[8'd31], eb);
    check("R7 reads total", 16'(reads - r0), 16'd2);
  endtask

  task automatic t_cfg_busy();
    logic [DW-1:0] e;
    set_cfg('0, 16'h00FF);
    e = expect_word(shadow[8'd40], 16'hFFFF, 2'b00);
    @(negedge clk);
    wr_valid = 1; wr_addr = 8'd40; wr_src = 16'hFFFF; wr_func = 2'b00;
    @(negedge clk);
    wr_valid = 0;
    cfg_we = 1; cfg_shift = 4'd3; cfg_mask = 16'hFF00;
    @(negedge clk);
    cfg_we = 0;
    while (!wr_ready) @(negedge clk);
    shadow[8'd40] = e; prev_m = 16'hFFFF;
    check("R10 op during load", mem[8'd40], e);
    run_op("R10 old cfg kept", 8'd41, 16'hFFFF, 2'b00);
    set_cfg('0, 16'hFFFF);
  endtask

  initial begin
    for (int i = 0; i < 2000000; i++) @(posedge clk);
  end

  initial begin
    int n;
    n = 0;
    while (n < 100000) begin
      @(posedge clk);
      n++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) shadow[i] = seed(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_functions();
    t_sequence();
    t_mask();
    t_shift();
    t_backpressure();
    t_cfg_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule